// File: doc/BRIEF.md
# Interrupt Trigger Notification Generator

The block watches a set of level-signalled interrupt inputs and turns each new assertion into a single 64-bit trigger store toward an interrupt controller. The store goes to a software-programmed notification address. Its data word combines a programmable interrupt-number offset with the index of the source. If the source asked for it, the word also carries a flag that says the event state was already checked. When the notification address is not marked valid, the trigger is discarded and no store is made.

Triggers that arrive while a store is still waiting for its acknowledge are held in a pending mask with one bit per source. They are issued one at a time, lowest source index first. A register port holds the rest of the block's state:
- a control word that enables store-style end-of-interrupt;
- an interrupt control word with a signalling-method bit and a source-reset bit;
- an event-page base word that carries a page-size bit and a mapping-enable bit;
- the notification address;
- the offset word.

The memory fabric appears as a plain request/acknowledge write interface. The acknowledge can carry an error indication.

Register bits are numbered most-significant-first where noted: bit k in that numbering is LSB position 63-k. Byte offsets are 0x20 control, 0x58 interrupt control, 0x60 event-page base, 0x68 notification address, 0x70 offset, 0x78 level (read only).

Top module: `irq_trig_notify`

## Requirements
- R1: After reset, every decoded register reads zero, no store is requested, and every flag and pulse output is low.
- R2: The level register at 0x78 shows input n at LSB position 63-n, follows the inputs one clock after they change, and ignores writes.
- R3: A rising input n with no store outstanding raises st_req_o two clocks later, with address equal to the notification register with bit 0 cleared and data equal to (offset register >> 32) OR n.
- R4: If src_chk_i[n] is high on the clock that registers the rising edge, bit 31 of that trigger's data word is set.
- R5: If bit 0 of the notification register is clear when a pending trigger is selected, that trigger is dropped and no store is issued.
- R6: A request holds its address and data until st_ack_i. An acknowledge with st_err_i high sets err_o, which stays set until reset, and that trigger is not retried.
- R7: Several pending triggers are issued one at a time in ascending source order, with one idle clock between an acknowledge and the next request.
- R8: While interrupt-control LSB bit 63 is set, the level register is frozen and no trigger is generated. method_err_o pulses, one clock later, in every clock in which the inputs differ from the frozen level.
- R9: A write to 0x58 with LSB bit 62 set stores the value and produces a single-clock src_rst_o pulse.
- R10: Event-page LSB bit 62 drives page_64k_o. A write that sets LSB bit 0 from clear pulses map_o for one clock, and a write that clears it from set pulses unmap_o for one clock.
- R11: Control-register LSB bit 51 drives store_eoi_o.
- R12: A read of any undecoded offset returns all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_level_i | input | 20 | Interrupt level inputs |
| src_chk_i | input | 20 | Per-source checked-flag request |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data (combinational) |
| st_req_o | output | 1 | Trigger store request |
| st_addr_o | output | 64 | Trigger store address |
| st_data_o | output | 64 | Trigger store data |
| st_ack_i | input | 1 | Store acknowledge |
| st_err_i | input | 1 | Store error, valid with acknowledge |
| err_o | output | 1 | Sticky store error |
| method_err_o | output | 1 | Input change ignored in level-signalled method |
| src_rst_o | output | 1 | Source-state reset pulse |
| page_64k_o | output | 1 | Event page size is 64 KiB |
| map_o | output | 1 | Event page mapping created |
| unmap_o | output | 1 | Event page mapping removed |
| store_eoi_o | output | 1 | Store-style end-of-interrupt enabled |

## Verification
Some properties are checked on every cycle:
- a request keeps its address and data stable until acknowledged;
- a request only starts when the notification address was valid;
- the error flag never falls;
- at most one pending bit is retired per clock;
- the level register stays frozen under the alternate method;
- map and unmap never pulse together.

Other behaviour only the bench scenarios can show: the exact data words, the ascending issue order with the checked flag, dropped triggers under an invalid address, and the bit placement of the level register. The bench checks these against its reference model.

// File: rtl/ntg_pkg.sv
package ntg_pkg;
  localparam int unsigned DW = 64;
  localparam int unsigned AW = 8;

  localparam logic [AW-1:0] OFF_CTRL  = 8'h20;
  localparam logic [AW-1:0] OFF_ICTL  = 8'h58;
  localparam logic [AW-1:0] OFF_PAGE  = 8'h60;
  localparam logic [AW-1:0] OFF_NOTIF = 8'h68;
  localparam logic [AW-1:0] OFF_IVT   = 8'h70;
  localparam logic [AW-1:0] OFF_LEVEL = 8'h78;

  // LSB-based positions of MSB-first numbered fields
  localparam int unsigned ICTL_METHOD = DW - 1 - 0;
  localparam int unsigned ICTL_RESET  = DW - 1 - 1;
  localparam int unsigned PAGE_64K    = DW - 1 - 1;
  localparam int unsigned PAGE_EN     = DW - 1 - 63;
  localparam int unsigned NOTIF_VLD   = DW - 1 - 63;
  localparam int unsigned CTRL_EOI    = DW - 1 - 12;
  localparam int unsigned IVT_SHIFT   = 32;

  typedef struct packed {
    logic [DW-1:0] addr;
    logic [DW-1:0] data;
  } store_t;
endpackage

// File: rtl/ntg_regs.sv
module ntg_regs
  import ntg_pkg::*;
#(
  parameter int unsigned NSRC = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NSRC-1:0] level_i,
  output logic [DW-1:0]   rdata_o,
  output logic            method_o,
  output logic [DW-1:0]   notif_o,
  output logic [DW-IVT_SHIFT-1:0] ivt_off_o,
  output logic            src_rst_o,
  output logic            page_64k_o,
  output logic            map_o,
  output logic            unmap_o,
  output logic            store_eoi_o
);
  logic [DW-1:0] ctrl_q, ictl_q, page_q, notif_q, ivt_q, lvl_rd;
  logic          rst_q, map_q, unmap_q;

  always_comb begin
    lvl_rd = '0;
    for (int n = 0; n < int'(NSRC); n++) lvl_rd[DW-1-n] = level_i[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; ictl_q <= '0; page_q <= '0; notif_q <= '0; ivt_q <= '0;
      rst_q <= 1'b0; map_q <= 1'b0; unmap_q <= 1'b0;
    end else begin
      rst_q   <= 1'b0;
      map_q   <= 1'b0;
      unmap_q <= 1'b0;
      if (we_i) begin
        unique case (addr_i)
          OFF_CTRL:  ctrl_q <= wdata_i;
          OFF_ICTL: begin
            ictl_q <= wdata_i;
            rst_q  <= wdata_i[ICTL_RESET];
          end
          OFF_PAGE: begin
            page_q  <= wdata_i;
            map_q   <= wdata_i[PAGE_EN] & ~page_q[PAGE_EN];
            unmap_q <= ~wdata_i[PAGE_EN] & page_q[PAGE_EN];
          end
          OFF_NOTIF: notif_q <= wdata_i;
          OFF_IVT:   ivt_q   <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_CTRL:  rdata_o = ctrl_q;
      OFF_ICTL:  rdata_o = ictl_q;
      OFF_PAGE:  rdata_o = page_q;
      OFF_NOTIF: rdata_o = notif_q;
      OFF_IVT:   rdata_o = ivt_q;
      OFF_LEVEL: rdata_o = lvl_rd;
      default:   rdata_o = '1;
    endcase
  end

  assign method_o    = ictl_q[ICTL_METHOD];
  assign notif_o     = notif_q;
  assign ivt_off_o   = ivt_q[DW-1:IVT_SHIFT];
  assign src_rst_o   = rst_q;
  assign page_64k_o  = page_q[PAGE_64K];
  assign map_o       = map_q;
  assign unmap_o     = unmap_q;
  assign store_eoi_o = ctrl_q[CTRL_EOI];

  assert_map_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(map_o && unmap_o));
  assert_rst_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_rst_o |=> !src_rst_o || $past(we_i && addr_i == OFF_ICTL));
endmodule

// File: rtl/ntg_level.sv
module ntg_level #(
  parameter int unsigned NSRC = 20
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] chk_i,
  input  logic            method_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] level_o,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] chk_o,
  output logic            merr_o
);
  logic [NSRC-1:0] level_q, pend_q, chk_q, fire;
  logic            merr_q;

  assign fire = method_i ? '0 : (src_i & ~level_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0; pend_q <= '0; chk_q <= '0; merr_q <= 1'b0;
    end else begin
      if (!method_i) level_q <= src_i;
      pend_q <= (pend_q & ~clr_i) | fire;
      chk_q  <= (chk_q & ~clr_i) | (fire & chk_i);
      merr_q <= method_i && (src_i != level_q);
    end
  end

  assign level_o = level_q;
  assign pend_o  = pend_q;
  assign chk_o   = chk_q;
  assign merr_o  = merr_q;

  assert_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    method_i |=> $stable(level_q));
  assert_one_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_i));
endmodule

// File: rtl/ntg_issue.sv
module ntg_issue
  import ntg_pkg::*;
#(
  parameter int unsigned NSRC    = 20,
  parameter int unsigned CHK_BIT = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] chk_i,
  input  logic [DW-1:0]   notif_i,
  input  logic [DW-IVT_SHIFT-1:0] ivt_off_i,
  input  logic            ack_i,
  input  logic            err_i,
  output logic [NSRC-1:0] clr_o,
  output logic            req_o,
  output store_t          st_o,
  output logic            err_o
);
  localparam int unsigned IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic          req_q, err_q, pick;
  store_t        st_q, st_n;
  logic [IW-1:0] idx;
  logic [DW-1:0] chk_word;

  always_comb begin
    idx = '0;
    for (int i = int'(NSRC) - 1; i >= 0; i--) if (pend_i[i]) idx = IW'(i);
  end

  assign pick = !req_q && (pend_i != '0);

  always_comb begin
    clr_o = '0;
    if (pick) clr_o[idx] = 1'b1;
  end

  assign chk_word  = chk_i[idx] ? (DW'(1) << CHK_BIT) : '0;
  assign st_n.addr = notif_i & ~(DW'(1) << NOTIF_VLD);
  assign st_n.data = DW'(ivt_off_i) | DW'(idx) | chk_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0; err_q <= 1'b0; st_q <= '0;
    end else if (req_q) begin
      if (ack_i) begin
        req_q <= 1'b0;
        if (err_i) err_q <= 1'b1;
      end
    end else if (pick && notif_i[NOTIF_VLD]) begin
      req_q <= 1'b1;
      st_q  <= st_n;
    end
  end

  assign req_o = req_q;
  assign st_o  = st_q;
  assign err_o = err_q;

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(st_o));
  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(notif_i[NOTIF_VLD]));
endmodule

// File: rtl/irq_trig_notify.sv
module irq_trig_notify
  import ntg_pkg::*;
#(
  parameter int unsigned NSRC    = 20,
  parameter int unsigned CHK_BIT = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_level_i,
  input  logic [NSRC-1:0] src_chk_i,
  input  logic            reg_we_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            st_req_o,
  output logic [DW-1:0]   st_addr_o,
  output logic [DW-1:0]   st_data_o,
  input  logic            st_ack_i,
  input  logic            st_err_i,
  output logic            err_o,
  output logic            method_err_o,
  output logic            src_rst_o,
  output logic            page_64k_o,
  output logic            map_o,
  output logic            unmap_o,
  output logic            store_eoi_o
);
  logic [NSRC-1:0] level, pend, chk, clr;
  logic            method;
  logic [DW-1:0]   notif;
  logic [DW-IVT_SHIFT-1:0] ivt_off;
  store_t          st;

  ntg_regs #(.NSRC(NSRC)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .level_i(level), .rdata_o(reg_rdata_o), .method_o(method), .notif_o(notif),
    .ivt_off_o(ivt_off), .src_rst_o, .page_64k_o, .map_o, .unmap_o, .store_eoi_o
  );

  ntg_level #(.NSRC(NSRC)) u_level (
    .clk_i, .rst_ni, .src_i(src_level_i), .chk_i(src_chk_i), .method_i(method),
    .clr_i(clr), .level_o(level), .pend_o(pend), .chk_o(chk), .merr_o(method_err_o)
  );

  ntg_issue #(.NSRC(NSRC), .CHK_BIT(CHK_BIT)) u_issue (
    .clk_i, .rst_ni, .pend_i(pend), .chk_i(chk), .notif_i(notif), .ivt_off_i(ivt_off),
    .ack_i(st_ack_i), .err_i(st_err_i), .clr_o(clr), .req_o(st_req_o), .st_o(st),
    .err_o
  );

  assign st_addr_o = st.addr;
  assign st_data_o = st.data;
endmodule

// File: tb/tb_irq_trig_notify.sv
module tb_irq_trig_notify;
  localparam int CLK_T = 10;
  localparam int NS = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src = '0, schk = '0;
  logic we = 1'b0, ack = 1'b0, aerr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [63:0] wdata = '0, rdata, st_addr, st_data;
  logic st_req, err_o, merr, srst, p64, map, unmap, eoi;

  irq_trig_notify dut (
    .clk_i(clk), .rst_ni(rst_n), .src_level_i(src), .src_chk_i(schk),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .st_req_o(st_req), .st_addr_o(st_addr), .st_data_o(st_data),
    .st_ack_i(ack), .st_err_i(aerr), .err_o(err_o), .method_err_o(merr),
    .src_rst_o(srst), .page_64k_o(p64), .map_o(map), .unmap_o(unmap),
    .store_eoi_o(eoi)
  );

  always #(CLK_T/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0, ack_dly = 1, ack_cnt = 0;
  bit ack_err_mode = 0, prev_req = 0;
  logic [63:0] log_q[$];

  // reference model state
  bit [63:0] m_ctrl, m_ictl, m_page, m_notif, m_ivt, m_addr, m_data;
  bit [NS-1:0] m_lvl, m_pend, m_chk;
  bit m_req, m_err, m_merr, m_rst, m_map, m_unmap;

  function automatic bit [63:0] m_read(input bit [7:0] a);
    bit [63:0] r;
    case (a)
      8'h20: r = m_ctrl;
      8'h58: r = m_ictl;
      8'h60: r = m_page;
      8'h68: r = m_notif;
      8'h70: r = m_ivt;
      8'h78: begin r = '0; for (int n = 0; n < NS; n++) r[63-n] = m_lvl[n]; end
      default: r = '1;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ictl = 0; m_page = 0; m_notif = 0; m_ivt = 0; m_addr = 0; m_data = 0;
      m_lvl = 0; m_pend = 0; m_chk = 0;
      m_req = 0; m_err = 0; m_merr = 0; m_rst = 0; m_map = 0; m_unmap = 0;
    end else begin
      bit meth;
      bit [NS-1:0] fire, clr;
      meth = m_ictl[63];
      fire = meth ? '0 : (src & ~m_lvl);
      clr = '0;
      m_merr = meth && (src != m_lvl);
      if (m_req) begin
        if (ack) begin m_req = 0; if (aerr) m_err = 1; end
      end else if (m_pend != 0) begin
        int lo;
        lo = -1;
        for (int i = 0; i < NS; i++) if (m_pend[i] && lo < 0) lo = i;
        clr[lo] = 1'b1;
        if (m_notif[0]) begin
          m_req = 1;
          m_addr = {m_notif[63:1], 1'b0};
          m_data = {32'h0, m_ivt[63:32]} | 64'(lo) | (m_chk[lo] ? 64'h8000_0000 : 64'h0);
        end
      end
      m_pend = (m_pend & ~clr) | fire;
      m_chk = (m_chk & ~clr) | (fire & schk);
      if (!meth) m_lvl = src;
      m_rst = 0; m_map = 0; m_unmap = 0;
      if (we) case (addr)
        8'h20: m_ctrl = wdata;
        8'h58: begin m_ictl = wdata; m_rst = wdata[62]; end
        8'h60: begin m_map = wdata[0] & ~m_page[0]; m_unmap = ~wdata[0] & m_page[0]; m_page = wdata; end
        8'h68: m_notif = wdata;
        8'h70: m_ivt = wdata;
        default: ;
      endcase
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, store log and acknowledge driver
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R3 req", 64'(st_req), 64'(m_req));
      if (m_req) begin
        check("R3 addr", st_addr, m_addr);
        check("R3 data", st_data, m_data);
      end
      check("R6 err", 64'(err_o), 64'(m_err));
      check("R8 merr", 64'(merr), 64'(m_merr));
      check("R9 srst", 64'(srst), 64'(m_rst));
      check("R10 map", {62'h0, map, unmap}, {62'h0, m_map, m_unmap});
      check("R10 64k", 64'(p64), 64'(m_page[62]));
      check("R11 eoi", 64'(eoi), 64'(m_ctrl[51]));
      if (st_req && !prev_req) log_q.push_back(st_data);
      prev_req = st_req;
      if (st_req && !ack) begin
        if (ack_cnt >= ack_dly) begin ack = 1; aerr = ack_err_mode; end
        else ack_cnt++;
      end else begin ack = 0; aerr = 0; ack_cnt = 0; end
    end
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input bit [7:0] a, input bit [63:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 8'h00;
  endtask

  task automatic rd(input string tag, input bit [7:0] a);
    @(negedge clk); #1 addr = a; #1 check(tag, rdata, m_read(a));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n0;
    idle(2); rst_n = 1;
    // R1 / R12
    rd("R1 ctrl", 8'h20); rd("R1 ictl", 8'h58); rd("R1 page", 8'h60);
    rd("R1 notif", 8'h68); rd("R1 ivt", 8'h70); rd("R1 level", 8'h78);
    check("R1 no req", 64'(st_req), 64'h0);
    rd("R12 undecoded", 8'h40); rd("R12 undecoded", 8'h08);
    check("R12 value", rdata, 64'hFFFF_FFFF_FFFF_FFFF);

    wr(8'h68, 64'h0000_1000_0000_0041);
    wr(8'h70, 64'h0000_0100_1234_5678);
    // R3 single source
    @(negedge clk); src[3] = 1;
    idle(6);
    check("R3 count", 64'(log_q.size()), 64'd1);
    if (log_q.size() > 0) check("R3 word", log_q[0], 64'h0000_0000_0000_0103);
    rd("R2 level src3", 8'h78);
    check("R2 bit60", 64'(rdata[60]), 64'd1);
    wr(8'h78, 64'h0);
    rd("R2 write ignored", 8'h78);

    // R7 / R4 simultaneous sources, slow ack
    ack_dly = 3;
    @(negedge clk); src = 20'h80021 | 20'h00008; schk = 20'h00020;
    @(negedge clk); schk = '0;
    idle(30);
    check("R7 count", 64'(log_q.size()), 64'd4);
    if (log_q.size() >= 4) begin
      check("R7 first", log_q[1], 64'h100);
      check("R4 chk src5", log_q[2], 64'h8000_0105);
      check("R7 last", log_q[3], 64'h113);
    end
    rd("R2 level many", 8'h78);
    ack_dly = 0;

    // R5 invalid address
    wr(8'h68, 64'h0000_2000_0000_0000);
    n0 = log_q.size();
    @(negedge clk); src = '0;
    @(negedge clk); src[7] = 1;
    idle(8);
    check("R5 dropped", 64'(log_q.size()), 64'(n0));
    wr(8'h68, 64'h0000_2000_0000_0001);
    idle(4);
    check("R5 not replayed", 64'(log_q.size()), 64'(n0));

    // R6 error response
    ack_err_mode = 1;
    @(negedge clk); src[9] = 1;
    idle(8);
    check("R6 err set", 64'(err_o), 64'd1);
    ack_err_mode = 0;
    @(negedge clk); src[10] = 1;
    idle(8);
    check("R6 err sticky", 64'(err_o), 64'd1);

    // R8 alternate method
    wr(8'h58, 64'h8000_0000_0000_0000);
    n0 = log_q.size();
    @(negedge clk); src = 20'hF0000;
    idle(4);
    rd("R8 level frozen", 8'h78);
    check("R8 no trigger", 64'(log_q.size()), 64'(n0));
    @(negedge clk); src = m_lvl;
    idle(2);
    wr(8'h58, 64'h0);
    idle(6);

    // R9 reset pulse
    wr(8'h58, 64'h4000_0000_0000_0000);
    rd("R9 stored", 8'h58);
    wr(8'h58, 64'h0);
    // R10 page register
    wr(8'h60, 64'h4000_0000_0001_0001);
    check("R10 64k out", 64'(p64), 64'd1);
    wr(8'h60, 64'h4000_0000_0001_0001);
    wr(8'h60, 64'h0000_0000_0001_0000);
    rd("R10 page", 8'h60);
    // R11 eoi
    wr(8'h20, 64'h0008_0000_0000_0000);
    check("R11 on", 64'(eoi), 64'd1);
    wr(8'h20, 64'h0);
    check("R11 off", 64'(eoi), 64'd0);
    idle(3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule